// File: doc/BRIEF.md
# Flash Read WAIT Signal Generator

This block produces the WAIT ready indicator of a parallel NOR-style flash interface, together with the enable that drives that pin out of high impedance. It watches the three active-low bus strobes (chip enable, output enable, write enable), a flag that selects synchronous or asynchronous reads, and a strap that says whether address and data share the bus. From these it decides whether WAIT is floated, held at its idle level, or used to pace a synchronous read.

During a synchronous read, WAIT is raised to its asserted level on the first clock edge of the read. It stays there until the array read path reports valid data through a one-cycle strobe, and then returns to its idle level. The asserted level comes from a polarity bit in the read configuration. That bit is captured only outside synchronous reads, so the pin's meaning cannot flip halfway through a burst.

The WAIT level and its enable both come straight from flip-flops. They therefore change only at rising clock edges, whatever the strobes do between edges.

The controller has six states:
- ST_DESEL: chip not selected.
- ST_OUTDIS: output disabled.
- ST_WRITE: write cycle.
- ST_ARD: asynchronous read.
- ST_SWAIT: synchronous read, data not yet valid.
- ST_SVALID: synchronous read, data valid.

The bus operation sampled at each edge names the next state, with two exceptions for synchronous reads. On entering a synchronous read, the controller always goes to ST_SWAIT first. ST_SWAIT moves to ST_SVALID on an edge where the data-valid strobe is high. ST_SVALID holds until the synchronous read ends.

Top module: `flash_wait_gen`

## Requirements
- R1: While reset is held and after it is released, with no other stimulus, wait_oe is 0 and wait_o is 1. The polarity bit resets to 0, which means active-low WAIT.
- R2: At any rising edge where ce_n is 1, the following registered output has wait_oe = 0 (high impedance). This holds for both bus types and from any state, including mid-read.
- R3: At an edge where ce_n=0, oe_n=0, we_n=1 and sync_mode=0 (asynchronous read), the outputs become wait_oe=1 with wait_o at the deasserted level.
- R4: At the first edge where ce_n=0, oe_n=0, we_n=1 and sync_mode=1 are seen after any other operation, the outputs become wait_oe=1 with wait_o at the asserted level. This happens even if data_vld is high at that edge.
- R5: During a synchronous read, WAIT stays asserted up to the first later edge at which data_vld is 1. From that edge on, it is deasserted for the rest of the read, whatever data_vld does afterwards.
- R6: At an edge where ce_n=0 and we_n=0 (write), wait_oe equals mux_bus: 0 on the separate address/data bus and 1 on the multiplexed bus. When driven, wait_o is deasserted.
- R7: At an edge where ce_n=0, oe_n=1 and we_n=1 (output disabled), wait_oe equals mux_bus. When driven, wait_o is deasserted.
- R8: The asserted level equals the polarity bit and the deasserted level is its inverse. With cfg_pol=0, asserted is logic 0; with cfg_pol=1, asserted is logic 1. When wait_oe is 0, wait_o still carries the deasserted level.
- R9: The polarity bit is loaded from cfg_pol at every edge except those where a synchronous read is already in progress and continues. Changes to cfg_pol during such a read have no effect on wait_o.
- R10: wait_o and wait_oe do not change between rising clock edges, even when the bus strobes change mid-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| sync_mode | input | 1 | 1 = reads are synchronous (burst), 0 = asynchronous |
| mux_bus | input | 1 | 1 = multiplexed address/data bus, 0 = separate buses |
| cfg_pol | input | 1 | Polarity bit from the read configuration (1 = WAIT asserted high) |
| data_vld | input | 1 | One-cycle strobe from the read path: output data is now valid |
| wait_o | output | 1 | Registered WAIT level |
| wait_oe | output | 1 | Registered pad enable for WAIT (0 = high impedance) |

## Verification
The assertions assume that the strobes, the mode flag, mux_bus and cfg_pol are steady around each rising edge, because they relate the inputs seen at one edge to the outputs after it. They also assume that data_vld only matters while a synchronous read is open. The bench changes every input just after the falling edge and holds it through the next rising edge. It pulses data_vld only inside synchronous reads, and checks between edges that no output has moved.

// File: rtl/flwait_pkg.sv
package flwait_pkg;

    // bus operation decoded from the strobes at one clock edge
    typedef enum logic [2:0] {
        OP_DESEL    = 3'd0,
        OP_OUTDIS   = 3'd1,
        OP_WRITE    = 3'd2,
        OP_RD_ASYNC = 3'd3,
        OP_RD_SYNC  = 3'd4
    } bus_op_e;

    // WAIT controller states
    typedef enum logic [2:0] {
        ST_DESEL  = 3'd0,
        ST_OUTDIS = 3'd1,
        ST_WRITE  = 3'd2,
        ST_ARD    = 3'd3,
        ST_SWAIT  = 3'd4,
        ST_SVALID = 3'd5
    } wait_st_e;

    localparam logic RESET_POL = 1'b0;

    function automatic logic is_sync_st(input wait_st_e s);
        return (s == ST_SWAIT) || (s == ST_SVALID);
    endfunction

endpackage

// File: rtl/flwait_decode.sv
module flwait_decode
    import flwait_pkg::*;
(
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    sync_mode,
    output bus_op_e op
);

    always_comb begin
        if (ce_n)
            op = OP_DESEL;
        else if (!we_n)
            op = OP_WRITE;
        else if (!oe_n)
            op = sync_mode ? OP_RD_SYNC : OP_RD_ASYNC;
        else
            op = OP_OUTDIS;
    end

endmodule

// File: rtl/flwait_fsm.sv
module flwait_fsm
    import flwait_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_op_e  op,
    input  logic     data_vld,
    output wait_st_e state_q,
    output wait_st_e state_d
);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_DESEL:    state_d = ST_DESEL;
            OP_OUTDIS:   state_d = ST_OUTDIS;
            OP_WRITE:    state_d = ST_WRITE;
            OP_RD_ASYNC: state_d = ST_ARD;
            OP_RD_SYNC: begin
                unique case (state_q)
                    ST_SWAIT:  state_d = data_vld ? ST_SVALID : ST_SWAIT;
                    ST_SVALID: state_d = ST_SVALID;
                    default:   state_d = ST_SWAIT;
                endcase
            end
            default:     state_d = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_DESEL;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/flwait_pol.sv
module flwait_pol
    import flwait_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic cfg_pol,
    output logic pol_q,
    output logic pol_n
);

    // value the polarity register takes at this edge
    assign pol_n = hold ? pol_q : cfg_pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pol_q <= RESET_POL;
        else
            pol_q <= pol_n;
    end

endmodule

// File: rtl/flwait_outreg.sv
module flwait_outreg
    import flwait_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wait_st_e state_d,
    input  logic     mux_bus,
    input  logic     pol_n,
    output logic     wait_o,
    output logic     wait_oe
);

    logic oe_d;
    logic asrt_d;
    logic lvl_d;

    // output decode per state
    always_comb begin
        oe_d   = 1'b0;
        asrt_d = 1'b0;
        unique case (state_d)
            ST_DESEL:  oe_d = 1'b0;
            ST_OUTDIS: oe_d = mux_bus;
            ST_WRITE:  oe_d = mux_bus;
            ST_ARD:    oe_d = 1'b1;
            ST_SWAIT: begin
                oe_d   = 1'b1;
                asrt_d = 1'b1;
            end
            ST_SVALID: oe_d = 1'b1;
            default:   oe_d = 1'b0;
        endcase
        lvl_d = asrt_d ? pol_n : ~pol_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_oe <= 1'b0;
            wait_o  <= ~RESET_POL;
        end else begin
            wait_oe <= oe_d;
            wait_o  <= lvl_d;
        end
    end

endmodule

// File: rtl/flash_wait_gen.sv
module flash_wait_gen
    import flwait_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic sync_mode,
    input  logic mux_bus,
    input  logic cfg_pol,
    input  logic data_vld,
    output logic wait_o,
    output logic wait_oe
);

    bus_op_e  op;
    wait_st_e state_q;
    wait_st_e state_d;
    logic     pol_q;
    logic     pol_n;
    logic     hold_pol;

    flwait_decode u_dec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .sync_mode (sync_mode),
        .op        (op)
    );

    flwait_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .data_vld (data_vld),
        .state_q  (state_q),
        .state_d  (state_d)
    );

    // freeze polarity only while a synchronous read continues
    assign hold_pol = is_sync_st(state_q) && (op == OP_RD_SYNC);

    flwait_pol u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold_pol),
        .cfg_pol (cfg_pol),
        .pol_q   (pol_q),
        .pol_n   (pol_n)
    );

    flwait_outreg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .mux_bus (mux_bus),
        .pol_n   (pol_n),
        .wait_o  (wait_o),
        .wait_oe (wait_oe)
    );

endmodule

// File: rtl/flwait_chk.sv
module flwait_chk
    import flwait_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     ce_n,
    input logic     oe_n,
    input logic     we_n,
    input logic     sync_mode,
    input logic     mux_bus,
    input logic     data_vld,
    input logic     wait_o,
    input logic     wait_oe,
    input logic     pol_q,
    input wait_st_e state_q
);

    logic rd_sync;
    logic rd_async;
    assign rd_sync  = !ce_n && !oe_n && we_n && sync_mode;
    assign rd_async = !ce_n && !oe_n && we_n && !sync_mode;

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !wait_oe); // R2

    AST_ASYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_async |=> (wait_oe && wait_o == !pol_q)); // R3

    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sync && !is_sync_st(state_q)) |=> (wait_oe && wait_o == pol_q)); // R4

    AST_SWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sync && state_q == ST_SWAIT && !data_vld) |=> (wait_o == pol_q)); // R5

    AST_VALID_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sync && (state_q == ST_SVALID || (state_q == ST_SWAIT && data_vld)))
        |=> (wait_oe && wait_o == !pol_q)); // R5

    AST_WRITE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (wait_oe == $past(mux_bus))); // R6

    AST_OUTDIS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && we_n) |=> (wait_oe == $past(mux_bus) && wait_o == !pol_q)); // R7

    AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sync && is_sync_st(state_q)) |=> $stable(pol_q)); // R9

endmodule

bind flash_wait_gen flwait_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .sync_mode (sync_mode),
    .mux_bus   (mux_bus),
    .data_vld  (data_vld),
    .wait_o    (wait_o),
    .wait_oe   (wait_oe),
    .pol_q     (pol_q),
    .state_q   (state_q)
);

// File: tb/sim_flash_wait_gen.sv
`timescale 1ns/1ps
module sim_flash_wait_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic sync_mode = 1'b0, mux_bus = 1'b0, cfg_pol = 1'b0, data_vld = 1'b0;
    logic wait_o, wait_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    flash_wait_gen u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .sync_mode(sync_mode), .mux_bus(mux_bus), .cfg_pol(cfg_pol),
        .data_vld(data_vld), .wait_o(wait_o), .wait_oe(wait_oe)
    );

    typedef struct {
        logic  oe;
        logic  lvl;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model state: 0 desel,1 outdis,2 write,3 async,4 swait,5 svalid
    int  m_st  = 0;
    logic m_pol = 1'b0;

    task automatic check(input string tag, input logic a_oe, input logic a_lvl,
                         input logic e_oe, input logic e_lvl);
        total++;
        if (a_oe !== e_oe || a_lvl !== e_lvl) begin
            bad++;
            $display("FAIL %s: oe/wait actual=%b/%b expected=%b/%b",
                     tag, a_oe, a_lvl, e_oe, e_lvl);
        end
    endtask

    // drive one cycle of inputs and queue the expected registered result
    task automatic drive(input string tag, input logic c, input logic o, input logic w,
                         input logic sm, input logic mx, input logic pl, input logic dv);
        logic before_oe, before_lvl, insync, pn, e_oe, asrt;
        int nst;
        @(negedge clk);
        before_oe  = wait_oe;
        before_lvl = wait_o;
        ce_n = c; oe_n = o; we_n = w; sync_mode = sm; mux_bus = mx;
        cfg_pol = pl; data_vld = dv;
        #1;
        check("R10 stable between edges", wait_oe, wait_o, before_oe, before_lvl);
        insync = (m_st == 4 || m_st == 5);
        if (c)               nst = 0;
        else if (!w)         nst = 2;
        else if (!o && !sm)  nst = 3;
        else if (!o)         nst = (m_st == 4) ? (dv ? 5 : 4) : (m_st == 5 ? 5 : 4);
        else                 nst = 1;
        pn = (insync && nst >= 4) ? m_pol : pl;
        e_oe = (nst == 0) ? 1'b0 : (nst == 1 || nst == 2) ? mx : 1'b1;
        asrt = (nst == 4);
        exp_q.push_back('{e_oe, asrt ? pn : ~pn, tag});
        m_st = nst;
        m_pol = pn;
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, wait_oe, wait_o, e.oe, e.lvl);
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset held", wait_oe, wait_o, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 after release", wait_oe, wait_o, 1'b0, 1'b1);

        drive("R2 deselected", 1, 1, 1, 0, 0, 0, 0);
        drive("R2 deselected mux", 1, 0, 1, 1, 1, 0, 0);
        drive("R3 async read", 0, 0, 1, 0, 0, 0, 0);
        drive("R3 async read mux", 0, 0, 1, 0, 1, 0, 0);
        drive("R6 write separate", 0, 1, 0, 0, 0, 0, 0);
        drive("R6 write mux", 0, 1, 0, 0, 1, 0, 0);
        drive("R7 outdis separate", 0, 1, 1, 0, 0, 0, 0);
        drive("R7 outdis mux", 0, 1, 1, 0, 1, 0, 0);
        // synchronous read, active-low WAIT; data_vld high at entry ignored
        drive("R4 sync entry", 0, 0, 1, 1, 0, 0, 1);
        drive("R5 still waiting", 0, 0, 1, 1, 0, 0, 0);
        drive("R5 still waiting", 0, 0, 1, 1, 0, 0, 0);
        drive("R5 data valid", 0, 0, 1, 1, 0, 0, 1);
        drive("R5 stays valid", 0, 0, 1, 1, 0, 0, 0);
        drive("R5 stays valid", 0, 0, 1, 1, 0, 0, 1);
        drive("R2 desel mid read", 1, 0, 1, 1, 0, 0, 0);
        // active-high WAIT
        drive("R8 load pol", 0, 1, 1, 1, 1, 1, 0);
        drive("R8 sync entry high", 0, 0, 1, 1, 1, 1, 0);
        drive("R9 pol change ignored", 0, 0, 1, 1, 1, 0, 0);
        drive("R9 pol change ignored", 0, 0, 1, 1, 1, 0, 0);
        drive("R9 valid at held pol", 0, 0, 1, 1, 1, 0, 1);
        drive("R8 write drives pol", 0, 1, 0, 1, 1, 0, 0);
        drive("R8 async at new pol", 0, 0, 1, 0, 1, 0, 0);
        drive("R4 async to sync", 0, 0, 1, 1, 1, 1, 0);
        drive("R6 write breaks read", 0, 0, 0, 1, 0, 1, 0);
        drive("R2 deselected end", 1, 1, 1, 0, 0, 1, 0);
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule